// File: doc/BRIEF.md
# Delay-Slot Branch Next-PC Resolver

This block sits beside the decode stage of a RISC pipeline that has a branch delay slot. It is given the address of a branch or jump, the 32-bit instruction word, the two source operands already read from the register file, the floating-point condition/status word and the DSP position value. From these it decides whether the instruction is a control transfer, whether a conditional one is taken, where execution resumes once the delay slot has run, and whether a return address has to be written to a link register.

The block covers five groups of control transfer. Jumps go either through a register or to an absolute region target. Branches compare two registers, or test the sign of one register. Floating-point branches test one condition code. One branch tests the DSP position value. Four branches test a single bit of a 64-bit operand. An unaligned branch address, and a DSP branch on a build without the DSP extension, are reported as fault flags and are not handled here. Outputs are captured in a register whenever the valid strobe is high and are held otherwise, so a result appears one cycle after its inputs.

Top module: `br_resolve`

## Requirements
- R1: When pc_i has either of its two low bits set, fault_unaligned_o is 1, is_branch_o is 0, link_we_o is 0 and new_pc_o equals pc_i, for any instruction word.
- R2: A taken conditional branch resumes at pc+4+(sign-extended instr[15:0] shifted left by 2); a branch that is not taken resumes at pc+8.
- R3: Opcode instr[31:26]=2 (jump) resumes at {bits 31:28 of pc+4, instr[25:0], 2'b00}; opcode 3 does the same and also writes pc+8 to register 31.
- R4: Opcode 0 with instr[5:0]=8 resumes at rs_val_i; with instr[5:0]=9 it also writes pc+8 to the register numbered by instr[15:11].
- R5: Opcode 6 branches when rs<=0 and opcode 7 when rs>0 (signed). Opcode 1 with instr[20:16] = 0 or 0x10 branches when rs<0, and with 1 or 0x11 when rs>=0. The 0x10 and 0x11 forms write pc+8 to register 31, taken or not.
- R6: Opcode 4 branches when rs_val_i equals rt_val_i, and opcode 5 when they differ.
- R7: The likely forms (opcodes 0x14..0x17; opcode 1 with instr[20:16] = 2, 3, 0x12 or 0x13) use the same condition, link and address rules as their plain forms.
- R8: Opcode 0x11 with instr[25:21]=8 is a floating-point branch on n=instr[20:18]. The tested fcsr_i bit is 23 for n=0 and 24+n otherwise. It branches when that bit equals instr[16].
- R9: Opcode 1 with instr[20:16]=0x1C branches when dsp_pos_i>=32. When HAS_DSP=0 it instead sets fault_illegal_o=1 and is_branch_o=1, with link_we_o=0 and new_pc_o=pc.
- R10: With HAS_BITTEST=1, opcodes 0x32/0x36 branch when bit b of rs is clear and 0x3A/0x3E when it is set. b is instr[20:16] for 0x32/0x3A and instr[20:16]+32 for 0x36/0x3E. With HAS_BITTEST=0 these opcodes are not branches.
- R11: Any other instruction word, including opcode 0x11 with instr[25:21]!=8, gives is_branch_o=0, link_we_o=0 and new_pc_o=pc.
- R12: A link write addressed to register 0 is suppressed (link_we_o=0), and link_we_o=1 always comes with a nonzero link_addr_o and link_data_o=pc+8.
- R13: After reset all outputs are 0. Outputs change only on a clock edge where valid_i is 1, one cycle after the inputs, and hold while valid_i is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Capture strobe for the inputs below |
| pc_i | input | PC_W | Address of the branch instruction |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | XLEN | Value of the first source register |
| rt_val_i | input | XLEN | Value of the second source register |
| fcsr_i | input | FCSR_W | Floating-point condition/status word |
| dsp_pos_i | input | DSP_W | DSP position value |
| new_pc_o | output | PC_W | Address where execution resumes after the delay slot |
| link_we_o | output | 1 | Link register write enable |
| link_addr_o | output | 5 | Link register number |
| link_data_o | output | XLEN | Return address to write |
| fault_unaligned_o | output | 1 | Branch address not word aligned |
| fault_illegal_o | output | 1 | DSP branch without the DSP extension |
| is_branch_o | output | 1 | Instruction is a recognised branch or jump |

## Verification
A wrong decode class appears directly at the ports one cycle after the strobe. It shows as a wrong is_branch_o, as a link write that should not happen, or as the pc+8 versus taken-target choice flipping. The floating-point bit map has a gap at bit 24. Vectors that set only bit 23, bit 24 or bit 25 expose an off-by-one in that map on the very next cycle. Stale or early capture shows up as outputs that move without a strobe, or that change in the same cycle as the inputs.

// File: rtl/br_pkg.sv
package br_pkg;

   localparam logic [5:0] OP_SPECIAL = 6'h00;
   localparam logic [5:0] OP_REGIMM  = 6'h01;
   localparam logic [5:0] OP_J       = 6'h02;
   localparam logic [5:0] OP_JAL     = 6'h03;
   localparam logic [5:0] OP_BEQ     = 6'h04;
   localparam logic [5:0] OP_BNE     = 6'h05;
   localparam logic [5:0] OP_BLEZ    = 6'h06;
   localparam logic [5:0] OP_BGTZ    = 6'h07;
   localparam logic [5:0] OP_FPU     = 6'h11;
   localparam logic [5:0] OP_BEQL    = 6'h14;
   localparam logic [5:0] OP_BNEL    = 6'h15;
   localparam logic [5:0] OP_BLEZL   = 6'h16;
   localparam logic [5:0] OP_BGTZL   = 6'h17;
   localparam logic [5:0] OP_BTC_LO  = 6'h32;
   localparam logic [5:0] OP_BTC_HI  = 6'h36;
   localparam logic [5:0] OP_BTS_LO  = 6'h3A;
   localparam logic [5:0] OP_BTS_HI  = 6'h3E;

   localparam logic [5:0] FN_JR      = 6'h08;
   localparam logic [5:0] FN_JALR    = 6'h09;
   localparam logic [4:0] FPU_BC     = 5'h08;
   localparam logic [4:0] LINK_REG   = 5'd31;

   typedef enum logic [3:0] {
      K_NONE, K_JREG, K_JABS, K_EQ, K_NE, K_LEZ, K_GTZ,
      K_LTZ, K_GEZ, K_FPC, K_DSP, K_BIT
   } br_kind_e;

   typedef struct packed {
      br_kind_e    kind;
      logic        link;
      logic [4:0]  link_rd;
      logic        sense;
      logic [2:0]  cc;
      logic [5:0]  bit_idx;
      logic        illegal;
   } br_dec_t;

endpackage

// File: rtl/br_decode.sv
module br_decode
   import br_pkg::*;
#(
   parameter bit HAS_DSP     = 1'b1,
   parameter bit HAS_BITTEST = 1'b1
) (
   input  logic [31:0] instr,
   output br_dec_t     dec
);

   logic [5:0] op;
   logic [4:0] rsf;
   logic [4:0] rtf;
   logic [4:0] rdf;
   logic [5:0] fn;
   logic       unused_shamt;

   assign op  = instr[31:26];
   assign rsf = instr[25:21];
   assign rtf = instr[20:16];
   assign rdf = instr[15:11];
   assign fn  = instr[5:0];
   assign unused_shamt = ^instr[10:6];

   always_comb begin
      dec         = '0;
      dec.kind    = K_NONE;
      dec.link_rd = LINK_REG;
      unique case (op)
         OP_SPECIAL: begin
            if (fn == FN_JR) begin
               dec.kind = K_JREG;
            end else if (fn == FN_JALR) begin
               dec.kind    = K_JREG;
               dec.link    = 1'b1;
               dec.link_rd = rdf;
            end
         end
         OP_REGIMM: begin
            unique case (rtf)
               5'h00, 5'h02: dec.kind = K_LTZ;
               5'h01, 5'h03: dec.kind = K_GEZ;
               5'h10, 5'h12: begin
                  dec.kind = K_LTZ;
                  dec.link = 1'b1;
               end
               5'h11, 5'h13: begin
                  dec.kind = K_GEZ;
                  dec.link = 1'b1;
               end
               5'h1C: begin
                  dec.kind    = K_DSP;
                  dec.illegal = !HAS_DSP;
               end
               default: dec.kind = K_NONE;
            endcase
         end
         OP_J:   dec.kind = K_JABS;
         OP_JAL: begin
            dec.kind = K_JABS;
            dec.link = 1'b1;
         end
         OP_BEQ,  OP_BEQL:  dec.kind = K_EQ;
         OP_BNE,  OP_BNEL:  dec.kind = K_NE;
         OP_BLEZ, OP_BLEZL: dec.kind = K_LEZ;
         OP_BGTZ, OP_BGTZL: dec.kind = K_GTZ;
         OP_FPU: begin
            if (rsf == FPU_BC) begin
               dec.kind  = K_FPC;
               dec.sense = rtf[0];
               dec.cc    = rtf[4:2];
            end
         end
         OP_BTC_LO, OP_BTC_HI, OP_BTS_LO, OP_BTS_HI: begin
            if (HAS_BITTEST) begin
               dec.kind    = K_BIT;
               dec.sense   = op[3];
               dec.bit_idx = {op[2], rtf};
            end
         end
         default: dec.kind = K_NONE;
      endcase
   end

endmodule

// File: rtl/br_cond.sv
module br_cond
   import br_pkg::*;
#(
   parameter int XLEN   = 64,
   parameter int FCSR_W = 32,
   parameter int DSP_W  = 6
) (
   input  br_dec_t            dec,
   input  logic [XLEN-1:0]    rs_val,
   input  logic [XLEN-1:0]    rt_val,
   input  logic [FCSR_W-1:0]  fcsr,
   input  logic [DSP_W-1:0]   dsp_pos,
   output logic               taken
);

   localparam logic [DSP_W-1:0] DSP_LIMIT = DSP_W'(32);

   logic       rs_neg;
   logic       rs_zero;
   logic [4:0] fp_bit;

   assign rs_neg  = rs_val[XLEN-1];
   assign rs_zero = (rs_val == '0);

   // condition code 0 sits at bit 23, codes 1..7 skip bit 24
   assign fp_bit = (dec.cc == 3'd0) ? 5'd23 : 5'(5'd24 + 5'(dec.cc));

   always_comb begin
      unique case (dec.kind)
         K_JREG, K_JABS: taken = 1'b1;
         K_EQ:           taken = (rs_val == rt_val);
         K_NE:           taken = (rs_val != rt_val);
         K_LEZ:          taken = rs_neg || rs_zero;
         K_GTZ:          taken = !rs_neg && !rs_zero;
         K_LTZ:          taken = rs_neg;
         K_GEZ:          taken = !rs_neg;
         K_FPC:          taken = (fcsr[fp_bit] == dec.sense);
         K_DSP:          taken = (dsp_pos >= DSP_LIMIT);
         K_BIT:          taken = (rs_val[dec.bit_idx] == dec.sense);
         default:        taken = 1'b0;
      endcase
   end

endmodule

// File: rtl/br_target.sv
module br_target
   import br_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic [PC_W-1:0] pc,
   input  logic [25:0]     fields,
   input  logic [PC_W-1:0] rs_pc,
   input  br_kind_e        kind,
   input  logic            taken,
   output logic [PC_W-1:0] next_pc,
   output logic [PC_W-1:0] ret_pc
);

   localparam int EXT_W = PC_W - 18;

   logic [PC_W-1:0] pc4;
   logic [PC_W-1:0] offset;
   logic [PC_W-1:0] rel_tgt;
   logic [PC_W-1:0] abs_tgt;

   assign pc4     = pc + PC_W'(4);
   assign ret_pc  = pc + PC_W'(8);
   assign offset  = {{EXT_W{fields[15]}}, fields[15:0], 2'b00};
   assign rel_tgt = pc4 + offset;
   assign abs_tgt = {pc4[PC_W-1:28], fields[25:0], 2'b00};

   always_comb begin
      unique case (kind)
         K_NONE:  next_pc = pc;
         K_JREG:  next_pc = rs_pc;
         K_JABS:  next_pc = abs_tgt;
         default: next_pc = taken ? rel_tgt : ret_pc;
      endcase
   end

endmodule

// File: rtl/br_resolve.sv
module br_resolve
   import br_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int XLEN        = 64,
   parameter int FCSR_W      = 32,
   parameter int DSP_W       = 6,
   parameter bit HAS_DSP     = 1'b1,
   parameter bit HAS_BITTEST = 1'b1,
   parameter bit REG_OUT     = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [31:0]       instr_i,
   input  logic [XLEN-1:0]   rs_val_i,
   input  logic [XLEN-1:0]   rt_val_i,
   input  logic [FCSR_W-1:0] fcsr_i,
   input  logic [DSP_W-1:0]  dsp_pos_i,
   output logic [PC_W-1:0]   new_pc_o,
   output logic              link_we_o,
   output logic [4:0]        link_addr_o,
   output logic [XLEN-1:0]   link_data_o,
   output logic              fault_unaligned_o,
   output logic              fault_illegal_o,
   output logic              is_branch_o
);

   if (PC_W < 29 || PC_W > XLEN) begin : g_bad_pcw
      $error("br_resolve: PC_W must lie in 29..XLEN");
   end
   if (HAS_BITTEST && XLEN < 64) begin : g_bad_xlen
      $error("br_resolve: bit-test branches need XLEN of at least 64");
   end
   if (FCSR_W < 32) begin : g_bad_fcsr
      $error("br_resolve: FCSR_W must be at least 32");
   end
   if (DSP_W < 6) begin : g_bad_dsp
      $error("br_resolve: DSP_W must be at least 6");
   end

   br_dec_t         dec;
   logic            taken;
   logic [PC_W-1:0] tgt_pc;
   logic [PC_W-1:0] ret_pc;

   br_decode #(.HAS_DSP(HAS_DSP), .HAS_BITTEST(HAS_BITTEST)) u_dec (
      .instr (instr_i),
      .dec   (dec)
   );

   br_cond #(.XLEN(XLEN), .FCSR_W(FCSR_W), .DSP_W(DSP_W)) u_cond (
      .dec     (dec),
      .rs_val  (rs_val_i),
      .rt_val  (rt_val_i),
      .fcsr    (fcsr_i),
      .dsp_pos (dsp_pos_i),
      .taken   (taken)
   );

   br_target #(.PC_W(PC_W)) u_tgt (
      .pc      (pc_i),
      .fields  (instr_i[25:0]),
      .rs_pc   (rs_val_i[PC_W-1:0]),
      .kind    (dec.kind),
      .taken   (taken),
      .next_pc (tgt_pc),
      .ret_pc  (ret_pc)
   );

   logic            c_unal;
   logic            c_isbr;
   logic            c_ill;
   logic            c_we;
   logic [PC_W-1:0] c_pc;
   logic [4:0]      c_addr;
   logic [XLEN-1:0] c_data;

   always_comb begin
      c_unal = (pc_i[1:0] != 2'b00);
      c_isbr = !c_unal && (dec.kind != K_NONE);
      c_ill  = c_isbr && dec.illegal;
      c_we   = c_isbr && !c_ill && dec.link && (dec.link_rd != 5'd0);
      c_pc   = (c_isbr && !c_ill) ? tgt_pc : pc_i;
      c_addr = c_we ? dec.link_rd : 5'd0;
      c_data = c_we ? XLEN'(ret_pc) : '0;
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            new_pc_o          <= '0;
            link_we_o         <= 1'b0;
            link_addr_o       <= '0;
            link_data_o       <= '0;
            fault_unaligned_o <= 1'b0;
            fault_illegal_o   <= 1'b0;
            is_branch_o       <= 1'b0;
         end else if (valid_i) begin
            new_pc_o          <= c_pc;
            link_we_o         <= c_we;
            link_addr_o       <= c_addr;
            link_data_o       <= c_data;
            fault_unaligned_o <= c_unal;
            fault_illegal_o   <= c_ill;
            is_branch_o       <= c_isbr;
         end
      end

      p_unaligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
         valid_i && (pc_i[1:0] != 2'b00) |=>
            fault_unaligned_o && !is_branch_o && !link_we_o && (new_pc_o == $past(pc_i)))
         else $error("unaligned address not faulted");

      p_link_data_r12: assert property (@(posedge clk) disable iff (!rst_n)
         valid_i |=> !link_we_o || (link_data_o == XLEN'($past(pc_i) + PC_W'(8))))
         else $error("link data is not the delay-slot return address");

      p_no_r0_r12: assert property (@(posedge clk) disable iff (!rst_n)
         link_we_o |-> (link_addr_o != 5'd0))
         else $error("link write aimed at register 0");

      p_nonbr_pc_r11: assert property (@(posedge clk) disable iff (!rst_n)
         valid_i |=> is_branch_o || (new_pc_o == $past(pc_i)))
         else $error("non-branch moved the pc");

      p_illegal_r9: assert property (@(posedge clk) disable iff (!rst_n)
         fault_illegal_o |-> is_branch_o && !fault_unaligned_o && !link_we_o)
         else $error("illegal fault with inconsistent flags");

      p_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
         !valid_i |=> $stable(new_pc_o) && $stable(link_we_o) && $stable(is_branch_o)
                      && $stable(fault_unaligned_o) && $stable(fault_illegal_o))
         else $error("outputs moved without a strobe");
   end else begin : g_comb
      logic unused_ctl;
      assign unused_ctl        = clk ^ rst_n ^ valid_i;
      assign new_pc_o          = c_pc;
      assign link_we_o         = c_we;
      assign link_addr_o       = c_addr;
      assign link_data_o       = c_data;
      assign fault_unaligned_o = c_unal;
      assign fault_illegal_o   = c_ill;
      assign is_branch_o       = c_isbr;
   end

endmodule

// File: tb/tb_br_resolve.sv
`timescale 1ns/1ps
module tb_br_resolve;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [31:0] pc_i = '0;
   logic [31:0] instr_i = '0;
   logic [63:0] rs_val_i = '0;
   logic [63:0] rt_val_i = '0;
   logic [31:0] fcsr_i = '0;
   logic [5:0]  dsp_pos_i = '0;

   logic [31:0] new_pc_o, nd_pc;
   logic        link_we_o, nd_we;
   logic [4:0]  link_addr_o, nd_addr;
   logic [63:0] link_data_o, nd_data;
   logic        fault_unaligned_o, nd_unal;
   logic        fault_illegal_o, nd_ill;
   logic        is_branch_o, nd_isbr;

   always #2 clk = ~clk;

   br_resolve dut (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .pc_i(pc_i), .instr_i(instr_i),
      .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .fcsr_i(fcsr_i), .dsp_pos_i(dsp_pos_i),
      .new_pc_o(new_pc_o), .link_we_o(link_we_o), .link_addr_o(link_addr_o),
      .link_data_o(link_data_o), .fault_unaligned_o(fault_unaligned_o),
      .fault_illegal_o(fault_illegal_o), .is_branch_o(is_branch_o)
   );

   br_resolve #(.HAS_DSP(1'b0), .HAS_BITTEST(1'b0)) dut_nd (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .pc_i(pc_i), .instr_i(instr_i),
      .rs_val_i(rs_val_i), .rt_val_i(rt_val_i), .fcsr_i(fcsr_i), .dsp_pos_i(dsp_pos_i),
      .new_pc_o(nd_pc), .link_we_o(nd_we), .link_addr_o(nd_addr),
      .link_data_o(nd_data), .fault_unaligned_o(nd_unal),
      .fault_illegal_o(nd_ill), .is_branch_o(nd_isbr)
   );

   typedef struct packed {
      logic [7:0]  req;
      logic [31:0] pc;
      logic [31:0] instr;
      logic [63:0] rs;
      logic [63:0] rt;
      logic [31:0] fcsr;
      logic [5:0]  dsp;
      logic [31:0] epc;
      logic        we;
      logic [4:0]  addr;
      logic        isbr;
      logic [1:0]  flt;
   } vec_t;

   localparam logic [31:0] P  = 32'h0040_1000;
   localparam logic [31:0] TK = 32'h0040_1044;
   localparam logic [31:0] NT = 32'h0040_1008;
   localparam logic [63:0] M1 = 64'hFFFF_FFFF_FFFF_FFFF;
   localparam int NV = 38;

   localparam vec_t VECS [NV] = '{
      '{8'd6,  P, 32'h1000_0010, 64'd5, 64'd5, 32'h0, 6'd0, TK, 1'b0, 5'd0, 1'b1, 2'b00}, // R6 eq taken
      '{8'd2,  P, 32'h1000_FFFF, 64'd5, 64'd5, 32'h0, 6'd0, P,  1'b0, 5'd0, 1'b1, 2'b00}, // R2 offset -4
      '{8'd6,  P, 32'h1400_0010, 64'd5, 64'd5, 32'h0, 6'd0, NT, 1'b0, 5'd0, 1'b1, 2'b00}, // R6 ne not taken
      '{8'd6,  P, 32'h1400_0010, 64'd5, 64'd6, 32'h0, 6'd0, TK, 1'b0, 5'd0, 1'b1, 2'b00}, // R6 ne taken
      '{8'd5,  P, 32'h1800_0010, 64'd0, 64'd0, 32'h0, 6'd0, TK, 1'b0, 5'd0, 1'b1, 2'b00}, // R5 lez zero
      '{8'd5,  P, 32'h1C00_0010, 64'd0, 64'd0, 32'h0, 6'd0, NT, 1'b0, 5'd0, 1'b1, 2'b00}, // R5 gtz zero
      '{8'd5,  P, 32'h1C00_0010, 64'd1, 64'd0, 32'h0, 6'd0, TK, 1'b0, 5'd0, 1'b1, 2'b00}, // R5 gtz one
      '{8'd5,  P, 32'h1800_0010, M1,    64'd0, 32'h0, 6'd0, TK, 1'b0, 5'd0, 1'b1, 2'b00}, // R5 lez neg
      '{8'd5,  P, 32'h0400_0010, M1,    64'd0, 32'h0, 6'd0, TK, 1'b0, 5'd0, 1'b1, 2'b00}, // R5 ltz neg
      '{8'd5,  P, 32'h0401_0010, M1,    64'd0, 32'h0, 6'd0, NT, 1'b0, 5'd0, 1'b1, 2'b00}, // R5 gez neg
      '{8'd5,  P, 32'h0410_0010, 64'd1, 64'd0, 32'h0, 6'd0, NT, 1'b1, 5'd31,1'b1, 2'b00}, // R5 link not taken
      '{8'd7,  P, 32'h0413_0010, 64'd0, 64'd0, 32'h0, 6'd0, TK, 1'b1, 5'd31,1'b1, 2'b00}, // R7 likely link
      '{8'd7,  P, 32'h5000_0010, 64'd7, 64'd7, 32'h0, 6'd0, TK, 1'b0, 5'd0, 1'b1, 2'b00}, // R7 eq likely
      '{8'd7,  P, 32'h5C00_0010, 64'd0, 64'd0, 32'h0, 6'd0, NT, 1'b0, 5'd0, 1'b1, 2'b00}, // R7 gtz likely
      '{8'd3,  32'h3FFF_FFFC, 32'h0812_3456, 64'd0, 64'd0, 32'h0, 6'd0, 32'h4048_D158, 1'b0, 5'd0, 1'b1, 2'b00}, // R3 region carry
      '{8'd3,  P, 32'h0C00_0004, 64'd0, 64'd0, 32'h0, 6'd0, 32'h0000_0010, 1'b1, 5'd31, 1'b1, 2'b00}, // R3 jal
      '{8'd4,  P, 32'h0000_0008, 64'h1234_5678, 64'd0, 32'h0, 6'd0, 32'h1234_5678, 1'b0, 5'd0, 1'b1, 2'b00}, // R4 jr
      '{8'd4,  P, 32'h0000_2809, 64'h00AB_CDE0, 64'd0, 32'h0, 6'd0, 32'h00AB_CDE0, 1'b1, 5'd5, 1'b1, 2'b00}, // R4 jalr rd5
      '{8'd12, P, 32'h0000_0009, 64'h100, 64'd0, 32'h0, 6'd0, 32'h0000_0100, 1'b0, 5'd0, 1'b1, 2'b00}, // R12 rd0
      '{8'd8,  P, 32'h4500_0010, 64'd0, 64'd0, 32'h0000_0000, 6'd0, TK, 1'b0, 5'd0, 1'b1, 2'b00}, // R8 false cc0
      '{8'd8,  P, 32'h4501_0010, 64'd0, 64'd0, 32'h0080_0000, 6'd0, TK, 1'b0, 5'd0, 1'b1, 2'b00}, // R8 true cc0
      '{8'd8,  P, 32'h4505_0010, 64'd0, 64'd0, 32'h0080_0000, 6'd0, NT, 1'b0, 5'd0, 1'b1, 2'b00}, // R8 cc1 bit23 only
      '{8'd8,  P, 32'h4505_0010, 64'd0, 64'd0, 32'h0200_0000, 6'd0, TK, 1'b0, 5'd0, 1'b1, 2'b00}, // R8 cc1 bit25
      '{8'd8,  P, 32'h451C_0010, 64'd0, 64'd0, 32'h8000_0000, 6'd0, NT, 1'b0, 5'd0, 1'b1, 2'b00}, // R8 false cc7
      '{8'd8,  P, 32'h4501_0010, 64'd0, 64'd0, 32'h0100_0000, 6'd0, NT, 1'b0, 5'd0, 1'b1, 2'b00}, // R8 bit24 unused
      '{8'd9,  P, 32'h041C_0010, 64'd0, 64'd0, 32'h0, 6'd32, TK, 1'b0, 5'd0, 1'b1, 2'b00}, // R9 pos 32
      '{8'd9,  P, 32'h041C_0010, 64'd0, 64'd0, 32'h0, 6'd31, NT, 1'b0, 5'd0, 1'b1, 2'b00}, // R9 pos 31
      '{8'd10, P, 32'hC803_0010, 64'h8, 64'd0, 32'h0, 6'd0, NT, 1'b0, 5'd0, 1'b1, 2'b00}, // R10 clear lo
      '{8'd10, P, 32'hF81F_0010, 64'h8000_0000_0000_0000, 64'd0, 32'h0, 6'd0, TK, 1'b0, 5'd0, 1'b1, 2'b00}, // R10 set bit63
      '{8'd10, P, 32'hD800_0010, 64'hFFFF_FFFE_FFFF_FFFF, 64'd0, 32'h0, 6'd0, TK, 1'b0, 5'd0, 1'b1, 2'b00}, // R10 clear bit32
      '{8'd10, P, 32'hE800_0010, 64'h1, 64'd0, 32'h0, 6'd0, TK, 1'b0, 5'd0, 1'b1, 2'b00}, // R10 set bit0
      '{8'd11, P, 32'h2400_0010, 64'd0, 64'd0, 32'h0, 6'd0, P, 1'b0, 5'd0, 1'b0, 2'b00}, // R11 alu op
      '{8'd11, P, 32'h4400_0000, 64'd0, 64'd0, 32'h0, 6'd0, P, 1'b0, 5'd0, 1'b0, 2'b00}, // R11 fpu non-branch
      '{8'd11, P, 32'h040C_0010, 64'd0, 64'd0, 32'h0, 6'd0, P, 1'b0, 5'd0, 1'b0, 2'b00}, // R11 regimm trap
      '{8'd11, P, 32'h0000_0020, 64'd0, 64'd0, 32'h0, 6'd0, P, 1'b0, 5'd0, 1'b0, 2'b00}, // R11 special add
      '{8'd1,  32'h0040_1002, 32'h1000_0010, 64'd5, 64'd5, 32'h0, 6'd0, 32'h0040_1002, 1'b0, 5'd0, 1'b0, 2'b10}, // R1
      '{8'd5,  P, 32'h0410_0010, M1, 64'd0, 32'h0, 6'd0, TK, 1'b1, 5'd31, 1'b1, 2'b00}, // R5 link taken
      '{8'd2,  P, 32'h1000_7FFF, 64'd3, 64'd3, 32'h0, 6'd0, 32'h0042_1000, 1'b0, 5'd0, 1'b1, 2'b00}  // R2 max offset
   };

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   task automatic drive(input logic [31:0] pc, input logic [31:0] ins, input logic [63:0] rs,
                        input logic [63:0] rt, input logic [31:0] fc, input logic [5:0] dp);
      @(negedge clk);
      pc_i = pc; instr_i = ins; rs_val_i = rs; rt_val_i = rt; fcsr_i = fc; dsp_pos_i = dp;
      valid_i = 1'b1;
      @(negedge clk);
      valid_i = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R13: reset values
      chk("R13", "reset pc", 64'(new_pc_o), 64'h0);
      chk("R13", "reset flags", 64'({link_we_o, is_branch_o, fault_unaligned_o, fault_illegal_o}), 64'h0);
      chk("R13", "reset link", 64'(link_data_o) | 64'(link_addr_o), 64'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         string tag;
         tag = $sformatf("R%0d", VECS[i].req);
         drive(VECS[i].pc, VECS[i].instr, VECS[i].rs, VECS[i].rt, VECS[i].fcsr, VECS[i].dsp);
         chk(tag, $sformatf("v%0d new_pc", i), 64'(new_pc_o), 64'(VECS[i].epc));
         chk(tag, $sformatf("v%0d is_branch", i), 64'(is_branch_o), 64'(VECS[i].isbr));
         chk(tag, $sformatf("v%0d link_we", i), 64'(link_we_o), 64'(VECS[i].we));
         chk(tag, $sformatf("v%0d faults", i), 64'({fault_unaligned_o, fault_illegal_o}), 64'(VECS[i].flt));
         if (VECS[i].we) begin
            chk(tag, $sformatf("v%0d link_addr", i), 64'(link_addr_o), 64'(VECS[i].addr));
            chk(tag, $sformatf("v%0d link_data", i), link_data_o, 64'(VECS[i].pc + 32'd8));
         end
      end

      // R9: DSP branch without the extension faults as illegal
      drive(P, 32'h041C_0010, 64'd0, 64'd0, 32'h0, 6'd40);
      chk("R9", "nodsp illegal", 64'({nd_ill, nd_isbr, nd_we, nd_unal}), 64'b1100);
      chk("R9", "nodsp pc", 64'(nd_pc), 64'(P));
      chk("R9", "dsp present no fault", 64'(fault_illegal_o), 64'h0);

      // R10: bit-test opcodes are not branches when the option is off
      drive(P, 32'hE800_0010, 64'h1, 64'd0, 32'h0, 6'd0);
      chk("R10", "no bittest isbr", 64'(nd_isbr), 64'h0);
      chk("R10", "no bittest pc", 64'(nd_pc), 64'(P));

      // R1: unaligned jump-and-link raises no link write
      drive(32'h0040_1001, 32'h0C00_0004, 64'd0, 64'd0, 32'h0, 6'd0);
      chk("R1", "unaligned jal", 64'({fault_unaligned_o, link_we_o, is_branch_o}), 64'b100);
      chk("R1", "unaligned pc", 64'(new_pc_o), 64'h0040_1001);

      // R13: one cycle latency, and hold while the strobe is low
      drive(P, 32'h1000_0010, 64'd5, 64'd5, 32'h0, 6'd0);
      @(negedge clk);
      pc_i = 32'h0000_2000; instr_i = 32'h1400_0010; rs_val_i = 64'd1; rt_val_i = 64'd2;
      repeat (3) @(negedge clk);
      chk("R13", "hold pc", 64'(new_pc_o), 64'(TK));
      chk("R13", "hold isbr", 64'(is_branch_o), 64'h1);
      valid_i = 1'b1;
      #1;
      chk("R13", "no same-cycle change", 64'(new_pc_o), 64'(TK));
      @(negedge clk);
      valid_i = 1'b0;
      chk("R13", "capture after edge", 64'(new_pc_o), 64'h0000_2044);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule